// File: doc/BRIEF.md
# Digital Phase Frequency Detector with Anti-Backlash Delay

This block compares the rising edges of two divided clock streams, a reference and a feedback signal, inside one fast sampling clock domain. A rising edge on the reference sets a flag that drives `up_o`. A rising edge on the feedback sets a second flag that drives `dn_o`. Once both flags are high, a counted hold-off keeps them high for a programmable number of sampling cycles, then clears them together. The difference in pulse width between `up_o` and `dn_o` is the phase error in sampling cycles. Because of the forced common overlap, a zero phase error still produces two equal, non-zero pulses, so the detector has no dead zone.

A lock monitor compares the two pulse widths at every clear event. It raises `lock_o` after a run of well-matched comparisons and drops it on the first poor one. Both asynchronous inputs pass through a synchroniser chain and a rising-edge detector before they can set a flag.

Top module: `pfd_top`

## Requirements
- R1: A rising edge on `ref_in` (or `fb_in`) that is first sampled high at clock edge k sets `up_o` (or `dn_o`) at edge k+2. The flag then stays high until a clear, whatever its input does.
- R2: Once `up_o` and `dn_o` are both high, they stay high together for exactly E cycles and fall at the same edge. E = `dly_cfg`, or 1 when `dly_cfg` is 0.
- R3: A `dly_cfg` value of 0 gives the same overlap as a value of 1.
- R4: When both inputs rise in the same sampling cycle, `up_o` and `dn_o` are identical pulses E cycles wide.
- R5: When the inputs rise d cycles apart, the earlier one's output is high d cycles longer than the other's. Both outputs end at the same edge.
- R6: An edge on an input that would set its flag at the same edge as the clear leaves that flag set after the clear.
- R7: `lock_o` rises at the clear edge of the LOCK_COUNT-th (default 16) consecutive comparison in which the `up_o` and `dn_o` widths differ by at most LOCK_TOL (default 1) cycle.
- R8: `lock_o` falls at the clear edge of the first comparison whose width difference exceeds LOCK_TOL. The run count then starts again from zero.
- R9: A synchronous active-high `rst` clears both flags, the overlap counter, the synchronisers and `lock_o`. After reset all outputs are 0, and the next overlap has the full width E.
- R10: Neither `up_o` nor `dn_o` ever falls unless the other output was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference divider output, asynchronous |
| fb_in | input | 1 | Feedback divider output, asynchronous |
| dly_cfg | input | DLY_W | Anti-backlash overlap in sampling cycles (0 acts as 1) |
| up_o | output | 1 | Pump-up pulse, driven by the reference flag |
| dn_o | output | 1 | Pump-down pulse, driven by the feedback flag |
| lock_o | output | 1 | Lock indication from the width comparisons |

## Verification
A flag stuck in the wrong state shows up at `up_o` or `dn_o` within E+2 cycles of the next input edge. It appears as an overlap of the wrong length, or as one output falling while the other is low. A wrong value in the overlap counter changes the common tail of the next pulse pair, and the sweep compares every cycle of that pair. A wrong width counter or run counter in the lock monitor appears only at `lock_o`, and only at a clear edge. That is up to sixteen comparisons later, which is why the bench follows the expected run count across every comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // index of each detector channel
   typedef enum logic [0:0] {
      CH_REF = 1'b0,
      CH_FB  = 1'b1
   } pfd_chan_e;

   localparam int unsigned NUM_CH = 2;

   // saturating increment for width counters
   function automatic logic [15:0] sat_inc16(input logic [15:0] v, input logic [15:0] maxv);
      sat_inc16 = (v >= maxv) ? maxv : v + 16'd1;
   endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pfd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             both_i,
   input  logic [DLY_W-1:0] dly_cfg_i,
   output logic             fire_o
);
   generate
      if (DLY_W < 1) begin : g_bad_dly_w
         $error("pfd_clear_timer: DLY_W must be at least 1");
      end
   endgenerate

   logic [DLY_W-1:0] eff_dly;
   logic [DLY_W-1:0] last_idx;
   logic [DLY_W-1:0] cnt_q;

   // zero is treated as the minimum overlap of one cycle
   assign eff_dly  = (dly_cfg_i == '0) ? DLY_W'(1) : dly_cfg_i;
   assign last_idx = DLY_W'(eff_dly - DLY_W'(1));
   assign fire_o   = both_i && (cnt_q == last_idx);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (!both_i || fire_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DLY_W'(1);
      end
   end

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
   parameter int unsigned WID_W      = 8,
   parameter int unsigned LOCK_COUNT = 16,
   parameter int unsigned LOCK_TOL   = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic up_i,
   input  logic dn_i,
   input  logic cmp_i,
   output logic lock_o
);
   localparam int unsigned RUN_W   = $clog2(LOCK_COUNT + 1);
   localparam logic [WID_W-1:0] WID_MAX = {WID_W{1'b1}};

   generate
      if (LOCK_COUNT < 1) begin : g_bad_count
         $error("pfd_lock_mon: LOCK_COUNT must be at least 1");
      end
      if (WID_W < 2 || WID_W > 16) begin : g_bad_wid
         $error("pfd_lock_mon: WID_W must lie in 2..16");
      end
   endgenerate

   logic [WID_W-1:0] up_w_q, dn_w_q;
   logic [WID_W-1:0] wid_diff;
   logic [RUN_W-1:0] run_q;
   logic             match;
   logic             lock_q;

   assign wid_diff = (up_w_q > dn_w_q) ? (up_w_q - dn_w_q) : (dn_w_q - up_w_q);
   assign match    = (32'(wid_diff) <= LOCK_TOL);

   always_ff @(posedge clk) begin
      if (rst) begin
         up_w_q <= '0;
         dn_w_q <= '0;
      end else if (cmp_i) begin
         up_w_q <= '0;
         dn_w_q <= '0;
      end else begin
         if (up_i) up_w_q <= WID_W'(pfd_pkg::sat_inc16(16'(up_w_q), 16'(WID_MAX)));
         if (dn_i) dn_w_q <= WID_W'(pfd_pkg::sat_inc16(16'(dn_w_q), 16'(WID_MAX)));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= '0;
         lock_q <= 1'b0;
      end else if (cmp_i) begin
         if (match) begin
            if (32'(run_q) < LOCK_COUNT) run_q <= run_q + RUN_W'(1);
            lock_q <= (32'(run_q) + 1 >= LOCK_COUNT);
         end else begin
            run_q  <= '0;
            lock_q <= 1'b0;
         end
      end
   end

   assign lock_o = lock_q;

endmodule

// File: rtl/pfd_top.sv
module pfd_top #(
   parameter int unsigned DLY_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WID_W       = 8,
   parameter int unsigned LOCK_COUNT  = 16,
   parameter int unsigned LOCK_TOL    = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_in,
   input  logic             fb_in,
   input  logic [DLY_W-1:0] dly_cfg,
   output logic             up_o,
   output logic             dn_o,
   output logic             lock_o
);
   import pfd_pkg::*;

   logic [NUM_CH-1:0] raw_in;
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] flag_q;
   logic              both;
   logic              fire;

   assign raw_in[CH_REF] = ref_in;
   assign raw_in[CH_FB]  = fb_in;

   // one synchroniser and one edge-triggered flag per channel
   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
         pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[ch]),
            .rise_o   (rise[ch])
         );

         always_ff @(posedge clk) begin
            if (rst) begin
               flag_q[ch] <= 1'b0;
            end else if (fire) begin
               flag_q[ch] <= rise[ch];
            end else if (rise[ch]) begin
               flag_q[ch] <= 1'b1;
            end
         end
      end
   endgenerate

   assign both = &flag_q;

   pfd_clear_timer #(.DLY_W(DLY_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .both_i    (both),
      .dly_cfg_i (dly_cfg),
      .fire_o    (fire)
   );

   pfd_lock_mon #(
      .WID_W      (WID_W),
      .LOCK_COUNT (LOCK_COUNT),
      .LOCK_TOL   (LOCK_TOL)
   ) u_lock (
      .clk    (clk),
      .rst    (rst),
      .up_i   (flag_q[CH_REF]),
      .dn_i   (flag_q[CH_FB]),
      .cmp_i  (fire),
      .lock_o (lock_o)
   );

   assign up_o = flag_q[CH_REF];
   assign dn_o = flag_q[CH_FB];

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
   parameter int unsigned DLY_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [DLY_W-1:0] dly_cfg,
   input logic             up_o,
   input logic             dn_o,
   input logic             lock_o
);
   localparam logic [DLY_W:0] OVL_MAX = {(DLY_W+1){1'b1}};

   logic [DLY_W:0]   ovl_q;
   logic [DLY_W-1:0] ovl_dly_q;
   logic             dirty_q;
   logic [DLY_W:0]   ovl_min;

   always_ff @(posedge clk) begin
      if (rst) begin
         ovl_q     <= '0;
         ovl_dly_q <= '0;
         dirty_q   <= 1'b0;
      end else if (up_o && dn_o) begin
         if (ovl_q != OVL_MAX) ovl_q <= ovl_q + 1'b1;
         if (ovl_q == '0) begin
            ovl_dly_q <= dly_cfg;
            dirty_q   <= 1'b0;
         end else if (dly_cfg != ovl_dly_q) begin
            dirty_q <= 1'b1;
         end
      end else begin
         ovl_q <= '0;
      end
   end

   assign ovl_min = (ovl_dly_q == '0) ? (DLY_W+1)'(1) : {1'b0, ovl_dly_q};

   // R10
   up_fall_needs_dn_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(up_o) |-> $past(dn_o));

   // R10
   dn_fall_needs_up_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dn_o) |-> $past(up_o));

   // R2
   min_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(up_o && dn_o) && !(up_o && dn_o) && !dirty_q) |-> (ovl_q >= ovl_min));

   // R7
   lock_moves_on_cmp_chk: assert property (@(posedge clk) disable iff (rst)
      (lock_o != $past(lock_o)) |-> $past(up_o && dn_o));

   // R9
   reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!up_o && !dn_o && !lock_o));

endmodule

bind pfd_top pfd_checker #(.DLY_W(DLY_W)) u_pfd_checker (
   .clk     (clk),
   .rst     (rst),
   .dly_cfg (dly_cfg),
   .up_o    (up_o),
   .dn_o    (dn_o),
   .lock_o  (lock_o)
);

// File: tb/tb_pfd_top.sv
`timescale 1ns/1ps
module tb_pfd_top;
   localparam int DLY_W = 4;
   localparam int RUN   = 40;

   logic             clk = 1'b0;
   logic             rst;
   logic             ref_in, fb_in;
   logic [DLY_W-1:0] dly_cfg;
   logic             up_o, dn_o, lock_o;

   int checks = 0;
   int errors = 0;
   int exp_run = 0;
   logic exp_lock = 1'b0;

   always #10 clk = ~clk;

   pfd_top dut (
      .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
      .dly_cfg(dly_cfg), .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at the falling edge, sample at the next falling edge
   task automatic step(input logic r, input logic f);
      ref_in = r;
      fb_in  = f;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic lock_model(input bit good);
      if (good) begin
         if (exp_run < 16) exp_run++;
         exp_lock = (exp_run >= 16);
      end else begin
         exp_run  = 0;
         exp_lock = 1'b0;
      end
   endtask

   // pulses of 3 cycles starting at cycle ro (reference) and fo (feedback)
   task automatic run_pair(input int ro, input int fo, input int d);
      int a = ro + 2;
      int b = fo + 2;
      int e = (d == 0) ? 1 : d;
      int m = (a > b) ? a : b;
      string tag;
      dly_cfg = DLY_W'(d);
      if (d == 0) tag = "R3 R2";
      else if (ro == fo) tag = "R4 R2";
      else tag = "R5 R1 R2";
      for (int i = 0; i < RUN; i++) begin
         step(i >= ro && i < ro + 3, i >= fo && i < fo + 3);
         chk({tag, " up"}, up_o, (i >= a && i < m + e));
         chk({tag, " dn"}, dn_o, (i >= b && i < m + e));
      end
      lock_model((ro > fo ? ro - fo : fo - ro) <= 1);
      chk("R7 R8 lock", lock_o, exp_lock);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      ref_in = 1'b0;
      fb_in  = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      exp_run  = 0;
      exp_lock = 1'b0;
   endtask

   initial begin
      dly_cfg = '0;
      do_reset();
      chk("R9 reset up", up_o, 1'b0);
      chk("R9 reset dn", dn_o, 1'b0);
      chk("R9 reset lock", lock_o, 1'b0);

      // sweep of overlap setting against both edge offsets
      for (int d = 0; d <= 4; d++)
         for (int ro = 0; ro <= 6; ro++)
            for (int fo = 0; fo <= 6; fo++)
               run_pair(ro, fo, d);

      // R7: lock rises exactly on the 16th good comparison
      run_pair(0, 3, 2);
      for (int k = 1; k <= 16; k++) begin
         run_pair(k % 2, 0, 2);
         chk("R7 lock count", lock_o, (k >= 16));
      end

      // R9: reset in the middle of a pulse clears everything, lock included
      dly_cfg = 4'd3;
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      chk("R1 up before reset", up_o, 1'b1);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R9 up cleared", up_o, 1'b0);
      chk("R9 lock cleared", lock_o, 1'b0);
      do_reset();
      run_pair(1, 1, 3);

      // R8: lock drops on the first poor comparison
      for (int k = 0; k < 16; k++) run_pair(2, 2, 1);
      chk("R7 relock", lock_o, 1'b1);
      run_pair(0, 2, 1);
      chk("R8 unlock", lock_o, 1'b0);

      // R6: reference edge landing on the clear edge keeps UP set
      dly_cfg = 4'd4;
      for (int i = 0; i < RUN; i++) begin
         step((i <= 1) || (i >= 4 && i <= 6), (i <= 2) || (i >= 20 && i <= 22));
         chk("R6 up held", up_o, (i >= 2 && i <= 25));
         chk("R6 dn", dn_o, (i >= 2 && i <= 5) || (i >= 22 && i <= 25));
      end
      chk("R8 after R6", lock_o, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #8_000_000;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule